// File: doc/BRIEF.md
# Programmable Odd/Even Clock Divider Bank

This block is a bank of post-scale output dividers. Every lane takes one fast input clock and produces an output clock whose period is a programmable number of input cycles. The period is built from two independent counts: the number of input cycles the output stays high, and the number it stays low. An odd-correction flag ends the high time half an input period early, using the falling edge of the input clock. This keeps odd ratios close to a 50% duty cycle. A bypass flag sends the input clock to a lane's output without division.

All lanes share one configuration stream. A word carries both counts, the two flags and a lane-select field. Only the selected lane stores the word, in a pending register. A lane moves the pending setting into use only at the end of its current output period, so an update never produces a runt pulse. The configuration port follows valid/ready rules. A word transfers on a rising clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low only while `rst` is high, so the port applies back-pressure only during reset. A sender holding `cfg_valid` high during reset keeps its word until reset ends. To divide by a requested ratio D, software sets the low count to floor(D/2) and the high count to the same value. For odd D it adds one to the high count and sets the odd flag.

A synchronous reset does three things: it drives every output low, it restores the default setting in every lane, and it releases all lanes together so that their first high phases start on the same input edge.

Top module: `clkdiv_bank`

## Requirements
- R1: The configuration word is 23 bits: low count in bits 7:0, high count in bits 15:8, bypass in bit 16, odd flag in bit 17, lane select in bits 22:18.
- R2: With bypass 0 and odd 0, a lane's output is high for exactly the high count of input cycles and then low for exactly the low count, repeating with period high+low.
- R3: With bypass 0 and odd 1, the high time is (high count - 0.5) input periods and the low time is (low count + 0.5) input periods; the period is unchanged.
- R4: With bypass 1, the lane output equals the input clock.
- R5: A high or low count of 0 means 256 input cycles, so a ratio of 1 is reachable only through bypass.
- R6: A word changes only the lane whose index equals the select field; a select of 18 or more changes no lane.
- R7: A stored word takes effect only at the start of the lane's next output period; the period in progress finishes with the previous setting.
- R8: While `rst` is high every output is low and every lane returns to the default setting (high 1, low 1, no bypass, no odd); on the first edge after `rst` falls, all lanes start a high phase together.
- R9: `cfg_ready` is low while `rst` is high and high otherwise; a word transfers only when `cfg_valid` and `cfg_ready` are both high on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Bank accepts a configuration word |
| cfg_word | input | 23 | Counts, flags and lane select |
| clk_out | output | N_OUT (18) | Divided clock of each lane |

## Verification
Each lane's state shows up on its output as run lengths measured in input half-periods. A wrong counter value lengthens or shortens the very next high or low run. A pending setting that is applied at the wrong moment makes the period in which the write lands come out wrong. A stale falling-edge cut flop moves a high-run boundary by one half-period within the first period after the mode changes. Sampling once in each half of the input clock therefore shows any internal fault within one output period after the stimulus that exposes it.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 5;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = 8;
  localparam int BYP_BIT = 16;
  localparam int ODD_BIT = 17;
  localparam int SEL_LSB = 18;
  localparam int CFG_W   = SEL_LSB + SEL_W;

  typedef struct packed {
    logic             bypass;
    logic             odd;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
  } div_cfg_t;

  function automatic div_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    div_cfg_t c;
    c.bypass = w[BYP_BIT];
    c.odd    = w[ODD_BIT];
    c.hi_cnt = w[HI_LSB +: CNT_W];
    c.lo_cnt = w[LO_LSB +: CNT_W];
    return c;
  endfunction

  function automatic logic [SEL_W-1:0] cfg_lane(input logic [CFG_W-1:0] w);
    return w[SEL_LSB +: SEL_W];
  endfunction
endpackage

// File: rtl/clkdiv_cfg_decode.sv
module clkdiv_cfg_decode
  import clkdiv_pkg::*;
#(
  parameter int N_OUT = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] wr_stb
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_stb
    assign wr_stb[i] = fire && (sel == SEL_W'(i));
  end

  // R6: at most one lane stores any given word
  assert_one_lane_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb));
  // R9: nothing is stored while reset holds
  assert_no_store_in_reset_R9: assert property (@(posedge clk)
    rst |-> (wr_stb == '0));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter logic [CNT_W-1:0] DEF_HI = 1,
  parameter logic [CNT_W-1:0] DEF_LO = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  div_cfg_t cfg_in,
  output div_cfg_t act,
  output logic     phase_hi,
  output logic     last_hi
);
  localparam div_cfg_t DEF_CFG = '{bypass: 1'b0, odd: 1'b0,
                                   hi_cnt: DEF_HI, lo_cnt: DEF_LO};

  div_cfg_t         pend_q, act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             cnt_zero, boundary;

  assign cnt_zero = (cnt_q == '0);
  // in bypass the setting may be swapped on every input edge
  assign boundary = act_q.bypass || (!phase_q && cnt_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= DEF_CFG;
      act_q   <= DEF_CFG;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr) pend_q <= cfg_in;
      if (boundary) begin
        act_q   <= pend_q;
        phase_q <= 1'b1;
        cnt_q   <= pend_q.hi_cnt - CNT_W'(1);  // 0 wraps to 256 cycles
      end else if (cnt_zero) begin
        phase_q <= 1'b0;
        cnt_q   <= act_q.lo_cnt - CNT_W'(1);
      end else begin
        cnt_q   <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign act      = act_q;
  assign phase_hi = phase_q;
  assign last_hi  = phase_q && cnt_zero && !act_q.bypass;

  // R7: the setting in use only changes on a period boundary
  assert_swap_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(act_q));
  // R8: reset leaves the lane low at the end of a period
  assert_reset_parks_R8: assert property (@(posedge clk)
    rst |=> (!phase_q && cnt_q == '0));
  // R2: a high phase only begins at a boundary
  assert_high_starts_period_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q) |-> $past(boundary));
  // R2: a high phase only ends once its count is spent
  assert_high_ends_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage (
  input  logic clk,
  input  logic rst,
  input  logic phase_hi,
  input  logic last_hi,
  input  logic bypass,
  input  logic odd,
  output logic clk_o
);
  logic cut_q;

  // set in the middle of the final high cycle, cleared one half later
  always_ff @(negedge clk) begin
    if (rst) cut_q <= 1'b0;
    else     cut_q <= last_hi;
  end

  assign clk_o = bypass ? clk : (phase_hi && !(odd && cut_q));

  // R3: the half-cycle cut never reaches into a low phase's end
  assert_cut_follows_high_R3: assert property (@(posedge clk) disable iff (rst)
    (cut_q && !phase_hi) |=> !cut_q || phase_hi);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int               N_OUT  = 18,
  parameter logic [CNT_W-1:0] DEF_HI = 1,
  parameter logic [CNT_W-1:0] DEF_LO = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [N_OUT-1:0] clk_out
);
  logic [N_OUT-1:0] wr_stb;
  div_cfg_t         cfg_bus;
  logic             fire;

  assign cfg_ready = !rst;
  assign fire      = cfg_valid && cfg_ready;
  assign cfg_bus   = unpack_cfg(cfg_word);

  clkdiv_cfg_decode #(.N_OUT(N_OUT)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .sel    (cfg_lane(cfg_word)),
    .wr_stb (wr_stb)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    div_cfg_t act;
    logic     phase_hi, last_hi;

    clkdiv_counter #(.DEF_HI(DEF_HI), .DEF_LO(DEF_LO)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_stb[i]),
      .cfg_in   (cfg_bus),
      .act      (act),
      .phase_hi (phase_hi),
      .last_hi  (last_hi)
    );

    clkdiv_outstage u_out (
      .clk      (clk),
      .rst      (rst),
      .phase_hi (phase_hi),
      .last_hi  (last_hi),
      .bypass   (act.bypass),
      .odd      (act.odd),
      .clk_o    (clk_out[i])
    );
  end

  // R9: the port refuses words only during reset
  assert_ready_outside_reset_R9: assert property (@(posedge clk)
    !rst |-> cfg_ready);
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int N = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [22:0]   cfg_word = '0;
  logic [N-1:0]  clk_out;

  int n_checks = 0;
  int n_fail   = 0;

  clkdiv_bank dut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .clk_out(clk_out)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1 layout: sel[22:18] odd[17] bypass[16] hi[15:8] lo[7:0]
  function automatic logic [22:0] mk(input int sel, input bit byp, input bit odd,
                                     input int hi, input int lo);
    return {5'(sel), odd, byp, 8'(hi), 8'(lo)};
  endfunction

  // called at rising edge + 5 ns; returns at rising edge + 5 ns after capture
  task automatic write_cfg(input int sel, input bit byp, input bit odd,
                           input int hi, input int lo);
    cfg_word  = mk(sel, byp, odd, hi, lo);
    cfg_valid = 1'b1;
    check(cfg_ready === 1'b1, "R9 ready out of reset", cfg_ready, 1);
    #20;
    cfg_valid = 1'b0;
  endtask

  task automatic find_rise(input int idx);
    bit prev = clk_out[idx];
    for (int k = 0; k < 2000; k++) begin
      #10;
      if (!prev && clk_out[idx]) return;
      prev = clk_out[idx];
    end
    check(1'b0, "no rising output", 0, 1);
  endtask

  // starts on the first high sample, ends on the next one
  task automatic period(input int idx, output int hi, output int lo);
    hi = 1; lo = 0;
    for (int k = 0; k < 1200; k++) begin
      #10;
      if (clk_out[idx]) hi++; else break;
    end
    lo = 1;
    for (int k = 0; k < 1200; k++) begin
      #10;
      if (!clk_out[idx]) lo++; else break;
    end
  endtask

  // settle after a write, then measure one period in half-cycles
  task automatic expect_period(input int idx, input int ehi, input int elo,
                               input string req);
    int h, l;
    find_rise(idx);
    period(idx, h, l);
    period(idx, h, l);
    check(h == ehi, req, h, ehi);
    check(l == elo, req, l, elo);
  endtask

  task automatic t_reset_start;
    for (int k = 0; k < 6; k++) begin
      #10;
      check(clk_out == '0, "R8 low in reset", int'(clk_out), 0);
    end
    check(cfg_ready === 1'b0, "R9 ready low in reset", cfg_ready, 0);
    rst = 1'b0;
    #10;
    check(clk_out == '0, "R8 low before first edge", int'(clk_out), 0);
    #10;
    check(clk_out == {N{1'b1}}, "R8 aligned start", int'(clk_out), (1 << N) - 1);
    expect_period(5, 2, 2, "R8 default ratio");
  endtask

  task automatic t_even;
    write_cfg(2, 0, 0, 3, 5);
    expect_period(2, 6, 10, "R2 even high3 low5");
    write_cfg(3, 0, 0, 2, 2);
    expect_period(3, 4, 4, "R2 even high2 low2");
  endtask

  task automatic t_odd;
    write_cfg(7, 0, 1, 3, 2);
    expect_period(7, 5, 5, "R3 odd ratio5");
    write_cfg(8, 0, 1, 1, 1);
    expect_period(8, 1, 3, "R3 odd high1 low1");
  endtask

  task automatic t_bypass;
    write_cfg(10, 1, 0, 4, 4);
    expect_period(10, 1, 1, "R4 bypass follows input");
    write_cfg(10, 0, 0, 2, 1);
    expect_period(10, 4, 2, "R4 leave bypass");
  endtask

  task automatic t_zero;
    write_cfg(12, 0, 0, 0, 1);
    expect_period(12, 512, 2, "R5 zero high is 256");
    write_cfg(12, 0, 0, 1, 0);
    expect_period(12, 2, 512, "R5 zero low is 256");
  endtask

  task automatic t_select;
    write_cfg(20, 0, 0, 5, 5);
    write_cfg(16, 0, 0, 6, 1);
    expect_period(17, 2, 2, "R6 unselected lane kept");
    expect_period(16, 12, 2, "R6 selected lane stored");
    expect_period(3, 4, 4, "R6 earlier lane kept");
  endtask

  task automatic t_boundary;
    int h, l;
    write_cfg(2, 0, 0, 4, 4);
    expect_period(2, 8, 8, "R7 setup");
    find_rise(2);
    fork
      write_cfg(2, 0, 0, 1, 1);
      period(2, h, l);
    join
    check(h == 8, "R7 period in flight high", h, 8);
    check(l == 8, "R7 period in flight low", l, 8);
    period(2, h, l);
    check(h == 2 && l == 2, "R7 new setting next period", h * 100 + l, 202);
  endtask

  task automatic t_reset_again;
    rst = 1'b1;
    #20;
    for (int k = 0; k < 4; k++) begin
      #10;
      check(clk_out == '0, "R8 low in mid reset", int'(clk_out), 0);
    end
    check(cfg_ready === 1'b0, "R9 ready low mid reset", cfg_ready, 0);
    rst = 1'b0;
    #20;
    check(clk_out == {N{1'b1}}, "R8 realigned", int'(clk_out), (1 << N) - 1);
    expect_period(2, 2, 2, "R8 default restored");
    expect_period(12, 2, 2, "R8 default restored lane12");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    @(posedge clk);
    #5;
    t_reset_start();
    t_even();
    t_odd();
    t_bypass();
    t_zero();
    t_select();
    t_boundary();
    t_reset_again();
    finish_run();
  end
endmodule